// File: doc/BRIEF.md
# Dual-Enable Static RAM with Shared Data Bus

This block is a single-port static memory of 8192 words by 8 bits behind one shared, bidirectional data bus. It is reached through a 13-bit address, two chip enables of opposite polarity, an active-low output enable and an active-low write enable. The design is modelled on a sampling clock. The tristate bus is split into a data-in vector, a data-out vector and one bus-drive enable. The pad or bus fabric around the block combines these three into a real three-state pin. While the drive enable is low the bus has no defined level.

On every clock edge the block decodes the control inputs into one of four modes: standby, selected-idle, read or write. A write stores the bus word at the addressed location on that edge. A read drives the addressed word onto the bus. Each time the address moves, the driver is held off for a settling window of `BLANK_CYCLES` sampling clocks, so a stale word is never presented as valid data for the new address.

Top module: `dual_cs_sram`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits (8192 x 8 by default). A word written at an address is returned unchanged by a later read of that address, and writes to other addresses leave it alone.
- R2: The device is selected only while `ce1_n` is 0 and `ce2` is 1. If either enable was inactive at a clock edge, `bus_drive` is 0 after that edge.
- R3: If, at a clock edge, the device is selected, `oe_n` is 0, `we_n` is 1 and no settling window is pending, then after that edge `bus_drive` is 1 and `bus_out` holds the word stored at `addr`.
- R4: If `oe_n` was 1 at a clock edge, `bus_drive` is 0 after that edge.
- R5: If the device is selected and `we_n` is 0 at a clock edge, `bus_in` is stored at `addr` on that edge. After that edge `bus_drive` is 0, whatever the level of `oe_n`.
- R6: A write attempt with `we_n` 0 while the device is in standby (`ce1_n` = 1 or `ce2` = 0) leaves the memory unchanged.
- R7: When `addr` at a clock edge differs from its value at the previous edge, `bus_drive` stays 0 after that edge and after the next BLANK_CYCLES-1 edges. From the edge after that on, the new word is driven, provided the read conditions hold.
- R8: While `rst_n` is 0, `bus_drive` is 0. After reset, `bus_drive` stays 0 until the first edge that meets the read conditions.
- R9: An ongoing read ends one edge after `ce2` falls, `ce1_n` rises or `we_n` falls. When the read conditions return at an unchanged address, the word is driven again after one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| bus_in | input | DATA_W | Data arriving from the shared bus |
| bus_out | output | DATA_W | Data to place on the shared bus |
| bus_drive | output | 1 | Bus driver enable; 0 means high impedance |

## Verification
Assertions check on every cycle that the driver is off after any edge where an enable was inactive, where `oe_n` was high, where a write was requested, or where the address had just moved. They also check that the driver is never on while a settling window is still counting. These assertions only cover the cases where the bus must be off. That stored data comes back intact, that writes in standby leave the memory untouched, that the driver comes back on exactly BLANK_CYCLES edges after an address change, and that a read resumes after each kind of interruption can only be shown by the bench's directed scenarios.

// File: rtl/dual_cs_sram.sv
module dual_cs_sram #(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int BLANK_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_drive
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = (BLANK_CYCLES < 2) ? 1 : $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] BLANK_LOAD = CW'(BLANK_CYCLES);

  typedef enum logic [1:0] {
    M_STANDBY = 2'd0,
    M_IDLE    = 2'd1,
    M_READ    = 2'd2,
    M_WRITE   = 2'd3
  } mode_t;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     blank_q, blank_d;
  logic              selected, moved;
  mode_t             mode;

  assign selected = !ce1_n && ce2;
  assign moved    = addr != addr_q;

  always_comb begin
    if (!selected)    mode = M_STANDBY;
    else if (!we_n)   mode = M_WRITE;
    else if (!oe_n)   mode = M_READ;
    else              mode = M_IDLE;
  end

  always_comb begin
    if (moved)             blank_d = BLANK_LOAD;
    else if (blank_q != 0) blank_d = blank_q - 1'b1;
    else                   blank_d = '0;
  end

  always_ff @(posedge clk) begin
    if (mode == M_WRITE) mem[addr] <= bus_in;
    bus_out <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      blank_q   <= '0;
      bus_drive <= 1'b0;
    end else begin
      addr_q    <= addr;
      blank_q   <= blank_d;
      bus_drive <= (mode == M_READ) && (blank_d == 0);
    end
  end

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(ce1_n) == 1'b0 && $past(ce2) == 1'b1) |-> !bus_drive); // R2

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n) |-> !bus_drive); // R4

  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_n) |-> !bus_drive); // R5

  AST_MOVE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addr) != $past(addr_q)) |-> !bus_drive); // R7

  AST_DRIVE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (blank_q == 0)); // R7

  always_comb begin
    if (!rst_n) AST_RESET_HIZ: assert (!bus_drive); // R8
  end

endmodule

// File: tb/tb_dual_cs_sram.sv
`timescale 1ns/1ps
module tb_dual_cs_sram;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int BL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic          bus_drive;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  dual_cs_sram #(.ADDR_W(AW), .DATA_W(DW), .BLANK_CYCLES(BL)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
    .oe_n(oe_n), .we_n(we_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_drive(bus_drive)
  );

  always #10 clk = ~clk;

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic sel_on();
    ce1_n = 1'b0;
    ce2   = 1'b1;
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic oen);
    sel_on();
    addr = a; bus_in = d; we_n = 1'b0; oe_n = oen;
    step();
    chk(bus_drive == 1'b0, "R5", "driver off during write", bus_drive, 0);
    we_n = 1'b1;
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    sel_on();
    we_n = 1'b1; oe_n = 1'b0; addr = a;
    step(BL + 1);
    chk(bus_drive == 1'b1, req, "driver on for read", bus_drive, 1);
    chk(bus_out == exp, req, "read word", bus_out, exp);
  endtask

  task automatic t_reset();
    step(2);
    chk(bus_drive == 1'b0, "R8", "driver off in reset", bus_drive, 0);
    rst_n = 1'b1;
    step();
    chk(bus_drive == 1'b0, "R8", "driver off after reset while standby", bus_drive, 0);
  endtask

  task automatic t_patterns();
    do_write(13'h0000, 8'h00, 1'b1);
    do_write(13'h1FFF, 8'hFF, 1'b0);
    do_write(13'h1234, 8'hA5, 1'b0);
    do_write(13'h0001, 8'h5A, 1'b1);
    do_read(13'h0000, 8'h00, "R1");
    do_read(13'h1FFF, 8'hFF, "R1");
    do_read(13'h1234, 8'hA5, "R3");
    do_read(13'h0001, 8'h5A, "R1");
  endtask

  task automatic t_blank();
    do_read(13'h1234, 8'hA5, "R3");
    addr = 13'h1FFF;
    step();
    chk(bus_drive == 1'b0, "R7", "off on first edge after move", bus_drive, 0);
    step();
    chk(bus_drive == 1'b0, "R7", "off on second edge after move", bus_drive, 0);
    step();
    chk(bus_drive == 1'b1, "R7", "on once window ends", bus_drive, 1);
    chk(bus_out == 8'hFF, "R7", "new word after window", bus_out, 8'hFF);
  endtask

  task automatic t_oe_gate();
    do_read(13'h0001, 8'h5A, "R3");
    oe_n = 1'b1;
    step();
    chk(bus_drive == 1'b0, "R4", "oe_n high turns driver off", bus_drive, 0);
    oe_n = 1'b0;
    step();
    chk(bus_drive == 1'b1, "R9", "resume after oe_n", bus_drive, 1);
  endtask

  task automatic t_end_read();
    do_read(13'h0001, 8'h5A, "R3");
    ce2 = 1'b0;
    step();
    chk(bus_drive == 1'b0, "R9", "ce2 fall ends read", bus_drive, 0);
    chk(bus_drive == 1'b0, "R2", "deselected is high impedance", bus_drive, 0);
    ce2 = 1'b1;
    step();
    chk(bus_drive == 1'b1, "R9", "resume after ce2", bus_drive, 1);
    ce1_n = 1'b1;
    step();
    chk(bus_drive == 1'b0, "R9", "ce1_n rise ends read", bus_drive, 0);
    ce1_n = 1'b0;
    step();
    chk(bus_drive == 1'b1, "R9", "resume after ce1_n", bus_drive, 1);
    bus_in = 8'h5A; we_n = 1'b0;
    step();
    chk(bus_drive == 1'b0, "R9", "we_n fall ends read", bus_drive, 0);
    we_n = 1'b1;
    step();
    chk(bus_drive == 1'b1, "R9", "resume after we_n", bus_drive, 1);
    chk(bus_out == 8'h5A, "R9", "word after resume", bus_out, 8'h5A);
  endtask

  task automatic t_standby_write();
    addr = 13'h1234; bus_in = 8'h3C; we_n = 1'b0; oe_n = 1'b0;
    ce1_n = 1'b0; ce2 = 1'b0;
    step();
    chk(bus_drive == 1'b0, "R2", "off with ce2 low", bus_drive, 0);
    ce1_n = 1'b1; ce2 = 1'b1; bus_in = 8'hC3;
    step();
    chk(bus_drive == 1'b0, "R2", "off with ce1_n high", bus_drive, 0);
    we_n = 1'b1;
    do_read(13'h1234, 8'hA5, "R6");
  endtask

  task automatic t_overwrite();
    do_write(13'h0000, 8'h81, 1'b0);
    do_read(13'h0000, 8'h81, "R1");
    do_read(13'h0001, 8'h5A, "R1");
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_blank();
    t_oe_gate();
    t_end_read();
    t_standby_write();
    t_overwrite();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule